// File: doc/BRIEF.md
# I2C Master Interrupt Status and Vector Unit

This unit collects the one-cycle event pulses raised by an I2C master's bus engine and keeps them as sticky flags in a 16-bit status word. Software sees the flags through a small 16-bit register port. It can clear serviced flags by writing ones back to the status word. It can also read a vector register, which returns a small code for the most urgent pending transfer event and clears that event as part of the read. A separate enable word masks the flags onto a single level interrupt line.

The bus-busy flag is not sticky. It shows the current bus-busy input whenever the status word is read, so software can poll it before it starts a transfer. The register port decodes a word index: 0 is the status word, 1 is the enable word, 2 is the vector register and 3 reads as zero. Read data is registered. Writes take effect at the clock edge that samples them.

Top module: `i2cm_irq_unit`

## Requirements
- R1: After reset all sticky status flags and the enable word are zero, `irq_o` is low and `reg_rdata_o` is zero.
- R2: An event pulse on `ev_pulse_i` sets the status flag at the same bit position. The flag stays set until software clears it. The sticky positions are: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 8 address zero, 9 addressed as slave, 10 transmit underflow, 11 receive overrun, 13 receive drain, 14 transmit drain.
- R3: A write to word 0 clears every sticky flag whose data bit is 1 and leaves the flags under 0 data bits unchanged.
- R4: If an event pulse arrives in the same cycle as a clear of the same flag, the set wins. This holds for clears by a status write and for clears by a vector read.
- R5: Status bit 12 reads as the value of `bus_busy_i` at the read edge, and writes to it have no effect.
- R6: Status bits 5, 6, 7 and 15 always read 0 and ignore event pulses. The enable word (word 1) holds only bits 0 to 4, 13 and 14, and its other bits read 0.
- R7: `irq_o` is high exactly when some status flag and the enable bit at the same position are both 1. It follows every change of the status flags or the enable word in the cycle after the edge that made the change.
- R8: A read of word 2 returns a code in bits 2:0 and zeros above: 0 when none of bits 0 to 4 is set, otherwise 1 + the index of the lowest set bit among status bits 0 to 4. The codes are 1 arbitration lost, 2 no-ack, 3 access ready, 4 receive ready, 5 transmit ready.
- R9: A read of word 2 clears only the flag it reports. Repeated reads therefore step through the pending transfer events in ascending code order and end at 0.
- R10: The status flags at bits 8 to 11, 13 and 14 never take part in the vector code.
- R11: `reg_rdata_o` is loaded at the edge that samples `reg_rd_i` with the register value from before that edge. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_pulse_i | input | 16 | One-cycle event pulses from the bus engine, in status bit positions |
| bus_busy_i | input | 1 | Live bus-busy level |
| reg_addr_i | input | ADDR_W (2) | Register word index |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
All state changes take effect at one clock edge. A pulse, a write or a vector read sampled at edge k changes the flags right after k, and `irq_o` follows in the same cycle because it is a gate on registers. Read data is loaded at the sampling edge and shows values from before that edge. For this reason the bench drives every input on the falling edge and checks every result on the next falling edge, half a period after the edge that produced it. Vector walks read back one code per read, and each read is followed by a status read that confirms which flag was cleared.

// File: rtl/i2cm_irq_pkg.sv
package i2cm_irq_pkg;
  localparam int REG_W  = 16;
  localparam int VEC_N  = 5;             // status bits 0..VEC_N-1 feed the vector
  localparam int CODE_W = $clog2(VEC_N + 1);

  localparam int B_BSY = 12;

  localparam logic [REG_W-1:0] STICKY_MASK = 16'h6F1F;
  localparam logic [REG_W-1:0] IEN_MASK    = 16'h601F;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_IEN  = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // lowest pending index wins; code = index + 1, 0 when nothing pending
  function automatic logic [CODE_W-1:0] vec_code(input logic [VEC_N-1:0] pend);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = VEC_N - 1; i >= 0; i--)
      if (pend[i]) c = CODE_W'(i + 1);
    return c;
  endfunction

  function automatic logic [REG_W-1:0] code_to_bit(input logic [CODE_W-1:0] c);
    return (c == '0) ? '0 : (REG_W'(1) << (c - CODE_W'(1)));
  endfunction
endpackage

// File: rtl/i2cm_irq_status.sv
module i2cm_irq_status
  import i2cm_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ev_i,
  input  logic             bb_i,
  input  logic [REG_W-1:0] w1c_i,
  input  logic [REG_W-1:0] vclr_i,
  output logic [REG_W-1:0] view_o
);
  logic [REG_W-1:0] sticky_q;
  logic [REG_W-1:0] set_ev;
  logic [REG_W-1:0] clr_any;

  assign set_ev  = ev_i & STICKY_MASK;
  assign clr_any = (w1c_i | vclr_i) & STICKY_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (sticky_q & ~clr_any) | set_ev;
  end

  always_comb begin
    view_o        = sticky_q;
    view_o[B_BSY] = bb_i;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev != '0) |=> ((sticky_q & $past(set_ev)) == $past(set_ev))); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky_q & ~$past(sticky_q) & ~$past(ev_i)) == '0)); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((w1c_i != '0) && ((w1c_i & ev_i) == '0)) |=> ((sticky_q & $past(w1c_i)) == '0)); // R3
  AST_VCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((vclr_i != '0) && ((vclr_i & ev_i) == '0)) |=> ((sticky_q & $past(vclr_i)) == '0)); // R9
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (view_o & ~(STICKY_MASK | (REG_W'(1) << B_BSY))) == '0); // R6
endmodule

// File: rtl/i2cm_irq_enable.sv
module i2cm_irq_enable
  import i2cm_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_o
);
  logic [REG_W-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (wr_i) en_q <= wdata_i & IEN_MASK;
  end

  assign en_o = en_q;

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_o)); // R6
  AST_EN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_o == ($past(wdata_i) & IEN_MASK))); // R6
endmodule

// File: rtl/i2cm_irq_vector.sv
module i2cm_irq_vector
  import i2cm_irq_pkg::*;
(
  input  logic [VEC_N-1:0]  pend_i,
  input  logic              rd_i,
  output logic [CODE_W-1:0] code_o,
  output logic [REG_W-1:0]  clr_o
);
  assign code_o = vec_code(pend_i);
  assign clr_o  = rd_i ? code_to_bit(code_o) : '0;

  always_comb begin
    AST_VEC_ONE_CLEAR: assert ($onehot0(clr_o)); // R9
    AST_VEC_RANGE: assert (code_o <= CODE_W'(VEC_N)); // R8
    AST_VEC_ZERO: assert ((pend_i != '0) || (code_o == '0)); // R8
  end
endmodule

// File: rtl/i2cm_irq_unit.sv
module i2cm_irq_unit
  import i2cm_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  ev_pulse_i,
  input  logic              bus_busy_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic hit_stat, hit_ien, hit_vec;
  assign hit_stat = (reg_addr_i == ADDR_W'(SEL_STAT));
  assign hit_ien  = (reg_addr_i == ADDR_W'(SEL_IEN));
  assign hit_vec  = (reg_addr_i == ADDR_W'(SEL_VEC));

  logic [REG_W-1:0]  stat_view;
  logic [REG_W-1:0]  en_word;
  logic [REG_W-1:0]  w1c_mask;
  logic [REG_W-1:0]  vclr_mask;
  logic [CODE_W-1:0] vcode;
  logic              vec_rd;

  assign w1c_mask = (reg_wr_i && hit_stat) ? reg_wdata_i : '0;
  assign vec_rd   = reg_rd_i && hit_vec;

  i2cm_irq_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   (ev_pulse_i),
    .bb_i   (bus_busy_i),
    .w1c_i  (w1c_mask),
    .vclr_i (vclr_mask),
    .view_o (stat_view)
  );

  i2cm_irq_enable u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i && hit_ien),
    .wdata_i (reg_wdata_i),
    .en_o    (en_word)
  );

  i2cm_irq_vector u_vector (
    .pend_i (stat_view[VEC_N-1:0]),
    .rd_i   (vec_rd),
    .code_o (vcode),
    .clr_o  (vclr_mask)
  );

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    unique case (reg_addr_i)
      ADDR_W'(SEL_STAT): rd_mux = stat_view;
      ADDR_W'(SEL_IEN):  rd_mux = en_word;
      ADDR_W'(SEL_VEC):  rd_mux = REG_W'(vcode);
      default:           rd_mux = '0;
    endcase
  end

  logic [REG_W-1:0] rdata_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end
  assign reg_rdata_o = rdata_q;

  assign irq_o = |(stat_view & en_word);

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_i |=> $stable(reg_rdata_o)); // R11
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_word == '0) |-> !irq_o); // R7
  AST_VEC_READ_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> (reg_rdata_o[REG_W-1:CODE_W] == '0)); // R8
endmodule

// File: tb/test_i2cm_irq_unit.sv
module test_i2cm_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev = '0;
  logic        bb = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  i2cm_irq_unit i_i2cm_irq_unit (
    .clk(clk), .rst_n(rst_n), .ev_pulse_i(ev), .bus_busy_i(bb),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // all stimulus changes on the falling edge; results checked on the next one
  task automatic idle();
    @(negedge clk);
    ev = '0; wr = 1'b0; rd = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] e);
    ev = e;
    idle();
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    idle();
  endtask

  task automatic rreg(input logic [1:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1;
    idle();
    d = rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 rdata", rdata, 16'h0);
    rreg(2'd0, v); chk("R1 status", v, 16'h0);
    rreg(2'd1, v); chk("R1 enable", v, 16'h0);
  endtask

  task automatic t_set_w1c();
    logic [15:0] v;
    pulse(16'h0009);
    idle();
    rreg(2'd0, v); chk("R2 sticky", v, 16'h0009);
    wreg(2'd0, 16'h0001);
    rreg(2'd0, v); chk("R3 w1c partial", v, 16'h0008);
    wreg(2'd0, 16'h0000);
    rreg(2'd0, v); chk("R3 write zero", v, 16'h0008);
    wreg(2'd0, v);
    rreg(2'd0, v); chk("R3 write back", v, 16'h0000);
  endtask

  task automatic t_set_wins();
    logic [15:0] v;
    pulse(16'h0002);
    ev = 16'h0002; addr = 2'd0; wdata = 16'h0002; wr = 1'b1;
    idle();
    rreg(2'd0, v); chk("R4 set beats w1c", v, 16'h0002);
    wreg(2'd0, 16'h0002);
    pulse(16'h0001);
    ev = 16'h0001; addr = 2'd2; rd = 1'b1;
    idle();
    chk("R4 vector code", rdata, 16'h0001);
    rreg(2'd0, v); chk("R4 set beats vector clear", v, 16'h0001);
    wreg(2'd0, 16'hFFFF);
  endtask

  task automatic t_bus_busy();
    logic [15:0] v;
    bb = 1'b1;
    rreg(2'd0, v); chk("R5 busy live", v, 16'h1000);
    wreg(2'd0, 16'h1000);
    rreg(2'd0, v); chk("R5 busy write ignored", v, 16'h1000);
    bb = 1'b0;
    rreg(2'd0, v); chk("R5 busy drop", v, 16'h0000);
  endtask

  task automatic t_undefined();
    logic [15:0] v;
    pulse(16'h90E0);
    rreg(2'd0, v); chk("R6 undefined status", v, 16'h0000);
    wreg(2'd1, 16'hFFFF);
    rreg(2'd1, v); chk("R6 enable mask", v, 16'h601F);
    rreg(2'd3, v); chk("R6 spare word", v, 16'h0000);
    wreg(2'd1, 16'h0000);
  endtask

  task automatic t_irq();
    wreg(2'd1, 16'h0002);
    pulse(16'h0001);
    chk("R7 masked event", {15'b0, irq}, 16'h0);
    pulse(16'h0002);
    chk("R7 enabled event", {15'b0, irq}, 16'h1);
    wreg(2'd0, 16'h0002);
    chk("R7 cleared", {15'b0, irq}, 16'h0);
    wreg(2'd1, 16'h0001);
    chk("R7 enable after event", {15'b0, irq}, 16'h1);
    wreg(2'd0, 16'h0001);
    wreg(2'd1, 16'h2000);
    pulse(16'h2000);
    chk("R7 drain irq", {15'b0, irq}, 16'h1);
    wreg(2'd0, 16'h2000);
    chk("R7 drain clear", {15'b0, irq}, 16'h0);
    wreg(2'd1, 16'h0000);
  endtask

  task automatic t_vector();
    logic [15:0] v;
    pulse(16'h0014);
    pulse(16'h0001);
    rreg(2'd2, v); chk("R8 first code", v, 16'h0001);
    rreg(2'd0, v); chk("R9 only lowest cleared", v, 16'h0014);
    rreg(2'd2, v); chk("R9 second code", v, 16'h0003);
    rreg(2'd2, v); chk("R9 third code", v, 16'h0005);
    rreg(2'd2, v); chk("R8 none", v, 16'h0000);
    pulse(16'h0008);
    rreg(2'd2, v); chk("R8 rx ready code", v, 16'h0004);
    pulse(16'h0002);
    rreg(2'd2, v); chk("R8 nack code", v, 16'h0002);
    rreg(2'd0, v); chk("R9 empty", v, 16'h0000);
  endtask

  task automatic t_vector_other();
    logic [15:0] v;
    pulse(16'h6F00);
    rreg(2'd2, v); chk("R10 code zero", v, 16'h0000);
    rreg(2'd0, v); chk("R10 flags kept", v, 16'h6F00);
    wreg(2'd0, 16'hFFFF);
  endtask

  task automatic t_rdata_hold();
    logic [15:0] v;
    pulse(16'h0010);
    rreg(2'd0, v); chk("R11 read", v, 16'h0010);
    wreg(2'd0, 16'h0010);
    pulse(16'h0004);
    chk("R11 hold", rdata, 16'h0010);
    rreg(2'd0, v); chk("R11 pre-edge value", v, 16'h0004);
    wreg(2'd0, 16'hFFFF);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_reset();
    t_set_w1c();
    t_set_wins();
    t_bus_busy();
    t_undefined();
    t_irq();
    t_vector();
    t_vector_other();
    t_rdata_hold();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule